// File: doc/BRIEF.md
# Limit-Matching Counter Timer

This block is a memory-mapped interval timer. A prescaler divides the system clock down to a 2 MHz tick enable, and each tick advances a 22-bit counter by one step of 500 ns. The counter is compared with a programmable limit. When the next step would make the count equal to the limit, the block sets a sticky flag, raises a level interrupt and restarts the count from one step, not from zero.

Software reaches the timer through a two-word register port. The counter word holds the flag in bit 31 and the count in bits 30:9. The limit word holds the limit in the same bit range. Because the count restarts at one step, a period of N ticks is programmed by writing (N+1) shifted left by 9 into the limit word. Reading the limit word acknowledges the interrupt.

Top module: `lim_ctr_timer`

## Requirements
- R1: The count changes only on a prescaler tick, and a tick occurs once every SYS_HZ/TICK_HZ system clock cycles. After reset or after a limit write, the first tick comes that many cycles later. Each tick adds one to the count.
- R2: When `addr_i` is 0, `rdata_o` shows the counter word: the flag in bit 31, the count in bits 30:9, and zero in bits 8:0. When `addr_i` is 1, `rdata_o` shows the limit word: zero in bit 31, the limit in bits 30:9, and zero in bits 8:0.
- R3: The limit is nonzero and a tick would make the count equal to the limit. On that tick the flag sets and the count loads 1 instead.
- R4: A limit word of (N+1)<<9, written while the flag is clear, sets the flag exactly N ticks after the write.
- R5: Once set, the flag stays set until it is cleared as R6 or R7 describe. `irq_o` is high exactly while the flag is set.
- R6: A read strobe (`rd_i`) with `addr_i`=1 clears the flag on the next edge. If a match happens in the same cycle, the set takes priority. A read strobe with `addr_i`=0 has no side effect.
- R7: A write strobe (`wr_i`) with `addr_i`=1 stores wdata bits 30:9 as the limit. It also loads the count with 1, clears the flag and restarts the prescaler.
- R8: When the limit is zero, no match happens: the flag never sets, and after 0x3FFFFF the count wraps to 0 with no other effect.
- R9: Writes with `addr_i`=0 are ignored. Bits 8:0 and bit 31 of a limit write are discarded.
- R10: After reset the count is 1, the flag is clear, the limit is 0 and the prescaler phase is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle (side effects only) |
| addr_i | input | 1 | Register select: 0 counter word, 1 limit word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected word, combinational |
| irq_o | output | 1 | Level interrupt request, equal to the flag |

## Verification
The assertions check the following rules on every cycle:
- the count stays still between ticks;
- ticks never come back to back;
- a match sets the flag and loads 1;
- the flag holds while nothing clears it;
- a limit write always loads 1 and clears the flag;
- a zero limit never sets the flag and wraps the count to 0;
- the limit changes only on a limit write.

Some behaviour only the bench scenarios can show. These are the exact period for each programmed limit, the masking of the reserved bits when read back, that counter-word writes and counter-word reads have no effect, and that a limit read acknowledges the interrupt. The wrap at the top of the 22-bit field takes millions of ticks, so only the assertion covers it.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the limit-matching counter timer.
// Assumes a 32-bit register word with the count field sitting above
// a block of zero bits and below a single flag bit.
package tmr_pkg;
    localparam int WORD_W   = 32;
    localparam int CNT_W    = 22;
    localparam int CNT_LSB  = 9;
    localparam int FLAG_BIT = 31;

    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [WORD_W-1:0] word_t;

    // Register select encoding on addr_i
    typedef enum logic {
        SEL_COUNT = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Divides the system clock into a one-cycle tick enable every DIV cycles.
// Assumes DIV >= 1; restart_i forces the phase back to zero so the next
// tick comes exactly DIV cycles later.
module tmr_prescaler #(
    parameter int DIV = 25
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [PW-1:0] phase_q;

            assign tick_o = (phase_q == PW'(DIV - 1));

            // Phase counter: wraps after DIV cycles, restarts on request
            always_ff @(posedge clk_i) begin
                if (!rst_ni || restart_i) begin
                    phase_q <= '0;
                end else if (tick_o) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + 1'b1;
                end
            end

            // R1: ticks are single-cycle pulses, never adjacent
            p_tick_gap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
                tick_o |=> !tick_o);
        end else begin : g_nodiv
            logic unused_restart;
            assign unused_restart = restart_i;
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/tmr_core.sv
// Count register with limit comparison and sticky flag.
// Assumes tick_i is a one-cycle enable; load_i (limit write) takes
// priority over everything; a match outranks a same-cycle clear.
module tmr_core
    import tmr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic load_i,
    input  logic clr_i,
    input  cnt_t limit_i,
    output cnt_t count_o,
    output logic flag_o
);
    localparam cnt_t ONE_STEP = cnt_t'(1);

    cnt_t count_q;
    logic flag_q;
    cnt_t count_nxt;
    logic hit;

    // Next step and limit comparison (zero limit disables matching)
    always_comb begin
        count_nxt = count_q + ONE_STEP;
        hit       = (limit_i != '0) && (count_nxt == limit_i);
    end

    // Count register: reload on limit write or match, else step per tick
    always_ff @(posedge clk_i) begin
        if (!rst_ni || load_i) begin
            count_q <= ONE_STEP;
        end else if (tick_i) begin
            count_q <= hit ? ONE_STEP : count_nxt;
        end
    end

    // Sticky flag: set on match, cleared by acknowledge or limit write
    always_ff @(posedge clk_i) begin
        if (!rst_ni || load_i) begin
            flag_q <= 1'b0;
        end else if (tick_i && hit) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign count_o = count_q;
    assign flag_o  = flag_q;

    // R1: the count holds between ticks
    p_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && !load_i) |=> $stable(count_o));

    // R3: a tick reaching the limit sets the flag and restarts at one step
    p_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && limit_i != '0 && count_o + ONE_STEP == limit_i)
        |=> (flag_o && count_o == ONE_STEP));

    // R5: the flag persists while nothing clears it
    p_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_o && !clr_i && !load_i) |=> flag_o);

    // R7: a limit write always restarts and clears
    p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i |=> (count_o == ONE_STEP && !flag_o));

    // R8: zero limit never raises the flag
    p_nomatch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (limit_i == '0 && !flag_o && !load_i) |=> !flag_o);

    // R8: zero limit wraps the count silently to zero
    p_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !load_i && limit_i == '0 && count_o == '1) |=> count_o == '0);
endmodule

// File: rtl/tmr_regs.sv
// Register port: decodes strobes, holds the limit, muxes read data.
// Assumes single-cycle strobes and a combinational read path; bits
// below the count field and the top bit of the limit are not stored.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  wr_i,
    input  logic  rd_i,
    input  logic  addr_i,
    input  word_t wdata_i,
    input  cnt_t  count_i,
    input  logic  flag_i,
    output cnt_t  limit_o,
    output logic  load_o,
    output logic  clr_o,
    output word_t rdata_o
);
    cnt_t limit_q;
    logic sel_lim;
    logic unused_wbits;

    assign sel_lim      = (reg_sel_e'(addr_i) == SEL_LIMIT);
    assign unused_wbits = ^{wdata_i[FLAG_BIT], wdata_i[CNT_LSB-1:0]};

    // Strobe decode: only the limit word has write or read side effects
    always_comb begin
        load_o = wr_i && sel_lim;
        clr_o  = rd_i && sel_lim;
    end

    // Limit register: captures the count-aligned field of a limit write
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            limit_q <= '0;
        end else if (load_o) begin
            limit_q <= wdata_i[CNT_LSB +: CNT_W];
        end
    end

    // Read mux: flag and count for the counter word, limit for the other
    always_comb begin
        if (sel_lim) begin
            rdata_o = {1'b0, limit_q, {CNT_LSB{1'b0}}};
        end else begin
            rdata_o = {flag_i, count_i, {CNT_LSB{1'b0}}};
        end
    end

    assign limit_o = limit_q;

    // R9: the limit moves only on a limit-word write
    p_lim_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && addr_i) |=> $stable(limit_o));
endmodule

// File: rtl/lim_ctr_timer.sv
// Top of the limit-matching counter timer: prescaler, register port
// and count core. Assumes SYS_HZ is a whole multiple of TICK_HZ.
module lim_ctr_timer #(
    parameter int SYS_HZ  = 50_000_000,
    parameter int TICK_HZ = 2_000_000
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        wr_i,
    input  logic        rd_i,
    input  logic        addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        irq_o
);
    import tmr_pkg::*;

    localparam int DIV = (SYS_HZ / TICK_HZ < 1) ? 1 : SYS_HZ / TICK_HZ;

    logic tick;
    logic load;
    logic clr;
    cnt_t limit;
    cnt_t count;
    logic flag;

    tmr_prescaler #(.DIV(DIV)) u_pre (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (load),
        .tick_o    (tick)
    );

    tmr_regs u_regs (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .count_i (count),
        .flag_i  (flag),
        .limit_o (limit),
        .load_o  (load),
        .clr_o   (clr),
        .rdata_o (rdata_o)
    );

    tmr_core u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (tick),
        .load_i  (load),
        .clr_i   (clr),
        .limit_i (limit),
        .count_o (count),
        .flag_o  (flag)
    );

    assign irq_o = flag;

    // R5: the request follows the flag bit seen on the counter word
    p_irq_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!addr_i) |-> (irq_o == rdata_o[FLAG_BIT]));
endmodule

// File: tb/lim_ctr_timer_tb_top.sv
// Self-checking bench: vector loop over periods, then directed cases.
module lim_ctr_timer_tb_top;
    localparam int DIV = 4;
    localparam int NV  = 4;
    localparam int PERIODS [NV] = '{1, 2, 5, 9};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lim_ctr_timer #(.SYS_HZ(250_000_000), .TICK_HZ(62_500_000)) dut_i (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .wr_i    (wr),
        .rd_i    (rd),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Peek a word with no strobe, at the current negedge
    task automatic peek(input logic a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    // Write strobe for one edge; returns at the following negedge
    task automatic wr_reg(input logic a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 1'b0;
    endtask

    // Read strobe for one edge, capturing data before the edge
    task automatic rd_reg(input logic a, output logic [31:0] v);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd = 1'b0; addr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R10: reset state seen while reset is held
        peek(1'b0, v); chk("R10 count word", v, 32'h0000_0200);
        peek(1'b1, v); chk("R10 limit word", v, 32'h0);
        chk("R10 irq", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;
        // R1: first tick after DIV edges
        wait_n(DIV - 1);
        peek(1'b0, v); chk("R1 before tick", v, 32'h0000_0200);
        wait_n(1);
        peek(1'b0, v); chk("R1 after tick", v, 32'h0000_0400);
        // R9: a counter-word write is ignored
        wr_reg(1'b0, 32'hFFFF_FFFF);
        peek(1'b0, v); chk("R9 counter write ignored", v, 32'h0000_0400);
        // R9, R2: limit write drops bit 31 and bits 8:0
        wr_reg(1'b1, 32'hFFFF_FFFF);
        peek(1'b1, v); chk("R9 limit masked", v, 32'h7FFF_FE00);

        // Vector loop: R3/R4 period, R2 readback, R6 acknowledge
        for (int k = 0; k < NV; k++) begin
            int n;
            logic [31:0] lw;
            n  = PERIODS[k];
            lw = 32'(n + 1) << 9;
            wr_reg(1'b1, lw);
            wait_n(n * DIV - 1);
            peek(1'b0, v); chk("R4 no flag before period", v, 32'(n) << 9);
            chk("R5 irq low before period", {31'b0, irq}, 32'h0);
            wait_n(1);
            peek(1'b0, v); chk("R3 flag and restart at match", v, 32'h8000_0200);
            chk("R5 irq high at match", {31'b0, irq}, 32'h1);
            rd_reg(1'b1, v); chk("R2 limit readback", v, lw);
            chk("R6 limit read clears irq", {31'b0, irq}, 32'h0);
        end

        // R5: flag stays set across later ticks without acknowledge
        wr_reg(1'b1, 32'h0000_0600);
        wait_n(5 * DIV);
        chk("R5 sticky across ticks", {31'b0, irq}, 32'h1);
        // R6: a counter-word read has no side effect
        rd_reg(1'b0, v);
        chk("R6 counter read keeps irq", {31'b0, irq}, 32'h1);
        // R7: limit write clears flag and restarts count
        wr_reg(1'b1, 32'h0000_0A00);
        peek(1'b0, v); chk("R7 limit write restarts", v, 32'h0000_0200);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        // R8: zero limit never matches, count keeps rising
        wr_reg(1'b1, 32'h0);
        wait_n(20 * DIV);
        peek(1'b0, v); chk("R8 zero limit free runs", v, 32'd21 << 9);
        chk("R8 no irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule